// File: doc/BRIEF.md
# Ranked Interrupt Vector Arbiter

This unit is called by a processor core when it executes its vector-select instruction. It samples a pending flag and an enable bit for each of sixteen ranked slots, together with the program address of that instruction. From these it picks the best-ranked slot that may be served. It then builds the address of that slot's two-byte entry in a vector table and reads the entry through a synchronous byte-wide read port. It returns the 16-bit jump target, one cycle wide, with a done strobe.

Slot index 0 is the best rank, and each higher index ranks lower. The software-trap slot is index 0, and its pending flag alone makes it eligible. Some slots are reserved and can never request. Slot 15 is not a source. It is the fallback used when no slot qualifies, so a handler that ends by re-entering the vector-select instruction will eventually land in a default routine.

The unit keeps no history between calls. Serving the next source is simply another call made with the updated flags.

Top module: `ranked_vector_unit`

## Requirements
- R1: A maskable, non-reserved slot k (1 to 14) is eligible only when both `irq_pend[k]` and `irq_en[k]` are 1.
- R2: When several slots are eligible, the one with the lowest index is chosen and reported on `done_slot`.
- R3: When no slot is eligible, slot 15 is chosen, with table offsets E0/E1.
- R4: Slot 0 (software trap) is eligible whenever `irq_pend[0]` is 1, whatever the value of `irq_en[0]`.
- R5: Reserved slots 1 and 7 to 13 (mask 16'h3F82) are never chosen, even when both their pending and enable bits are set.
- R6: The entry for slot k has its low address byte at FE − 2·k (high byte of the target). The byte that follows it, at odd offset FF − 2·k, holds the low byte of the target.
- R7: The upper seven address bits of the entry equal `instr_addr[14:8]`. When `instr_addr[7:0]` is FF, they equal `instr_addr[14:8]` + 1 instead, which wraps from 7'h7F to 7'h00.
- R8: A request is accepted at edge E0, and `mem_rd_en` is then high for two cycles. In the first cycle `mem_addr` is the even entry address, and in the second it is the odd one. Read data returns one cycle after each read. `done` is high for exactly the one cycle after edge E3, with `target` = {even byte, odd byte}.
- R9: The pending, enable and address inputs are sampled only at acceptance. Changes made to them while the fetch is running do not alter `done_slot` or `target`.
- R10: A `sel_req` that arrives while a fetch is running is ignored. No extra read is started and the result is unchanged.
- R11: A synchronous active-high `rst` returns the unit to idle, with `done` and `mem_rd_en` low.
- R12: Repeated calls with the same inputs give the same result. After the served slot's pending flag is cleared, the next call serves the next-ranked eligible slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_req | input | 1 | Vector-select request; taken when the unit is idle |
| instr_addr | input | 15 | Program address of the vector-select instruction |
| irq_pend | input | 16 | Per-slot pending flags; bit k belongs to slot k |
| irq_en | input | 16 | Per-slot enable bits; bit k belongs to slot k |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | 15 | Table byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| done | output | 1 | One-cycle strobe marking a valid result |
| target | output | 16 | Jump target formed as {high byte, low byte} |
| done_slot | output | 4 | Slot that was chosen (0 = best rank) |

## Verification
The bench builds the unit with its default parameters: sixteen slots, a 15-bit program address space and the reserved mask 16'h3F82. With these values the page carry from an instruction at byte FF becomes reachable, including the wrap from the topmost block at 7FFF back to block 0. Every slot, the reserved slots and the fallback slot are also reachable. Random flag and enable patterns are mixed with directed cases: trap-only, reserved-only, empty, and a served-then-cleared chain. Inputs and requests are disturbed in the middle of each fetch.

// File: rtl/vec_arb_pkg.sv
package vec_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_HI   = 2'd1,
        ST_RD_LO   = 2'd2,
        ST_WAIT_LO = 2'd3
    } seq_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/irq_rank_picker.sv
module irq_rank_picker #(
    parameter int unsigned          NUM_SLOTS = 16,
    parameter int unsigned          IDX_W     = $clog2(NUM_SLOTS),
    parameter logic [NUM_SLOTS-1:0] RSVD_MASK = 16'h3F82,
    parameter int unsigned          NMI_SLOT  = 0
) (
    input  logic [NUM_SLOTS-1:0] pend,
    input  logic [NUM_SLOTS-1:0] enab,
    output logic [IDX_W-1:0]     slot
);

    localparam int unsigned DFLT_SLOT = NUM_SLOTS - 1;

    logic [NUM_SLOTS-1:0] elig;

    // Per-slot eligibility: reserved and fallback slots never request,
    // the non-maskable slot needs only its pending flag.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_elig
        if (RSVD_MASK[k] || k == DFLT_SLOT) begin : g_never
            assign elig[k] = 1'b0;
        end else if (k == NMI_SLOT) begin : g_nmi
            assign elig[k] = pend[k];
        end else begin : g_mask
            assign elig[k] = pend[k] & enab[k];
        end
    end

    // Fixed rank: scan from worst to best so the best eligible slot wins.
    always_comb begin
        slot = IDX_W'(DFLT_SLOT);
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (elig[k]) begin
                slot = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/vec_page_calc.sv
module vec_page_calc #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [IDX_W-1:0]  slot,
    output logic [ADDR_W-1:0] entry_addr
);

    import vec_arb_pkg::*;

    localparam int unsigned PAGE_W  = ADDR_W - BYTE_W;
    localparam logic [7:0]  TOP_OFF = 8'hFE;

    logic [PAGE_W-1:0] page;
    logic [7:0]        offset;
    logic              at_last;

    always_comb begin
        at_last    = &instr_addr[BYTE_W-1:0];
        // Instruction on a block's final byte: table lives in the next block,
        // wrapping modulo the address space.
        page       = instr_addr[ADDR_W-1:BYTE_W] + PAGE_W'(at_last);
        offset     = TOP_OFF - (8'(slot) << 1);
        entry_addr = {page, offset};
    end

endmodule

// File: rtl/ranked_vector_unit.sv
module ranked_vector_unit #(
    parameter int unsigned          NUM_SLOTS = 16,
    parameter int unsigned          ADDR_W    = 15,
    parameter logic [NUM_SLOTS-1:0] RSVD_MASK = 16'h3F82,
    parameter int unsigned          NMI_SLOT  = 0
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            sel_req,
    input  logic [ADDR_W-1:0]               instr_addr,
    input  logic [NUM_SLOTS-1:0]            irq_pend,
    input  logic [NUM_SLOTS-1:0]            irq_en,
    output logic                            mem_rd_en,
    output logic [ADDR_W-1:0]               mem_addr,
    input  logic [7:0]                      mem_rdata,
    output logic                            done,
    output logic [15:0]                     target,
    output logic [$clog2(NUM_SLOTS)-1:0]    done_slot
);

    import vec_arb_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_SLOTS);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  slot;
        logic [ADDR_W-1:0] entry;
        logic [7:0]        hi;
        logic [15:0]       tgt;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [IDX_W-1:0]  pick_slot;
    logic [ADDR_W-1:0] pick_entry;

    irq_rank_picker #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W),
        .RSVD_MASK (RSVD_MASK),
        .NMI_SLOT  (NMI_SLOT)
    ) u_picker (
        .pend (irq_pend),
        .enab (irq_en),
        .slot (pick_slot)
    );

    vec_page_calc #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_page (
        .instr_addr (instr_addr),
        .slot       (pick_slot),
        .entry_addr (pick_entry)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (sel_req) begin
                    r_d.slot  = pick_slot;
                    r_d.entry = pick_entry;
                    r_d.state = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                r_d.state = ST_RD_LO;
            end
            ST_RD_LO: begin
                r_d.hi    = mem_rdata;
                r_d.state = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                r_d.tgt   = {r_q.hi, mem_rdata};
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, slot: '0, entry: '0, hi: '0, tgt: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_rd_en = (r_q.state == ST_RD_HI) || (r_q.state == ST_RD_LO);
        mem_addr  = {r_q.entry[ADDR_W-1:1], r_q.state == ST_RD_LO};
        done      = r_q.done;
        target    = r_q.tgt;
        done_slot = r_q.slot;
    end

    // R8: result strobe lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: result follows the odd-byte read by two cycles
    assert_done_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_rd_en, 2) && $past(mem_addr[0], 2)));

    // R6: odd byte read directly follows the even byte of the same entry
    assert_odd_follows_even_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_addr[0]) |=>
            (mem_rd_en && mem_addr[0] &&
             mem_addr[ADDR_W-1:1] == $past(mem_addr[ADDR_W-1:1])));

    // R10: no new read starts right after the odd read, even with sel_req high
    assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_addr[0]) |=> !mem_rd_en);

    // R5: a reserved slot is never reported
    assert_no_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !RSVD_MASK[done_slot]);

    // R11: reset leaves the port quiet
    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (!done && !mem_rd_en));

endmodule

// File: tb/ranked_vector_unit_bench.sv
module ranked_vector_unit_bench;

    localparam logic [15:0] RSVD = 16'h3F82;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_req = 1'b0;
    logic [14:0] instr_addr = '0;
    logic [15:0] irq_pend = '0;
    logic [15:0] irq_en = '0;
    logic        mem_rd_en;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] target;
    logic [3:0]  done_slot;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ranked_vector_unit u_ranked_vector_unit (
        .clk, .rst, .sel_req, .instr_addr, .irq_pend, .irq_en,
        .mem_rd_en, .mem_addr, .mem_rdata, .done, .target, .done_slot
    );

    function automatic logic [7:0] mem_byte(input logic [14:0] a);
        return 8'(a[7:0] * 8'd29) ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_byte(mem_addr);
    end

    function automatic logic [3:0] exp_slot(input logic [15:0] p, input logic [15:0] e);
        for (int k = 0; k < 15; k++) begin
            if (!RSVD[k]) begin
                if (k == 0 && p[0]) return 4'd0;
                if (k != 0 && p[k] && e[k]) return 4'(k);
            end
        end
        return 4'd15;
    endfunction

    function automatic logic [14:0] exp_entry(input logic [14:0] ia, input logic [3:0] s);
        logic [6:0] pg;
        pg = ia[14:8] + 7'(&ia[7:0]);
        return {pg, 8'hFE - (8'(s) << 1)};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One call; optional disturbance of inputs and sel_req during the fetch.
    task automatic run_sel(input logic [14:0] ia, input logic [15:0] p, input logic [15:0] e,
                           input bit disturb, input string req);
        logic [3:0]  es;
        logic [14:0] ee;
        es = exp_slot(p, e);
        ee = exp_entry(ia, es);
        @(negedge clk);
        instr_addr = ia; irq_pend = p; irq_en = e; sel_req = 1'b1;
        @(negedge clk);                     // after E0
        if (disturb) begin
            irq_pend = 16'($urandom); irq_en = 16'($urandom);
            instr_addr = 15'($urandom); sel_req = 1'b1;
        end else sel_req = 1'b0;
        chk("R8", "even read strobe", 32'(mem_rd_en), 32'd1);
        chk("R6", "even address", 32'(mem_addr), 32'(ee));
        @(negedge clk);                     // after E1
        chk("R6", "odd address", 32'(mem_addr), 32'(ee | 15'd1));
        @(negedge clk);                     // after E2
        chk("R10", "no read while waiting", 32'(mem_rd_en), 32'd0);
        sel_req = 1'b0;
        @(negedge clk);                     // after E3
        chk("R8", "done strobe", 32'(done), 32'd1);
        chk(req, "slot", 32'(done_slot), 32'(es));
        chk("R8", "target", 32'(target), 32'({mem_byte(ee), mem_byte(ee | 15'd1)}));
        if (disturb) chk("R9", "slot under disturbance", 32'(done_slot), 32'(es));
        @(negedge clk);                     // after E4
        chk("R8", "done falls", 32'(done), 32'd0);
        chk("R10", "no extra fetch", 32'(mem_rd_en), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        sel_req = 1'b1;
        @(negedge clk);
        rst = 1'b0; sel_req = 1'b0;
        chk("R11", "done after reset", 32'(done), 32'd0);
        chk("R11", "read after reset", 32'(mem_rd_en), 32'd0);

        // Directed corners
        run_sel(15'h0123, 16'h0000, 16'hFFFF, 0, "R3");
        run_sel(15'h0456, RSVD, 16'hFFFF, 0, "R5");
        run_sel(15'h0200, 16'h0001, 16'h0000, 0, "R4");
        run_sel(15'h0300, 16'h4020, 16'h4000, 0, "R1");
        run_sel(15'h0300, 16'h4070, 16'hFFFF, 0, "R2");
        run_sel(15'h12FF, 16'h0008, 16'h0008, 0, "R7");
        run_sel(15'h7FFF, 16'h0010, 16'h0010, 0, "R7");
        run_sel(15'h7FFE, 16'h0010, 16'h0010, 0, "R7");
        run_sel(15'h0500, 16'h4078, 16'hFFFF, 1, "R9");
        // Served-then-cleared chain, with a repeat call
        run_sel(15'h0A10, 16'h4028, 16'h4028, 0, "R12");
        run_sel(15'h0A10, 16'h4028, 16'h4028, 0, "R12");
        run_sel(15'h0A10, 16'h4020, 16'h4028, 0, "R12");
        run_sel(15'h0A10, 16'h4000, 16'h4028, 0, "R12");
        run_sel(15'h0A10, 16'h0000, 16'h4028, 0, "R12");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [14:0] ia;
            logic [15:0] p;
            ia = 15'($urandom);
            if ($urandom_range(3) == 0) ia[7:0] = 8'hFF;
            p = 16'($urandom);
            if ($urandom_range(1) == 0) p = p & 16'($urandom) & 16'($urandom);
            run_sel(ia, p, 16'($urandom), bit'($urandom_range(1)), "R2");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule